// File: doc/BRIEF.md
# Transmit Sync Pulse Distribution Controller

This block hands a single-cycle synchronisation pulse to each of five transmit sub-blocks: the sample FIFO, the clock divider, the quadrature offset corrector, the quadrature gain/phase corrector and the coarse mixer. A pulse can come from one of two sources. The first is an external sync pin, which the block resynchronises and edge-detects. The second is a software trigger bit that a register write sets.

There are two routing modes. In global mode, one shared source feeds every target: either the pin or a single global trigger bit. In per-block mode, each target can be switched off, or it can pick between the pin and its own dedicated trigger bit. A trigger bit fires only when a write changes it from 0 to 1. Three registers hold the settings, and they are written and read back through a plain address/data/strobe port. The readback is combinational on the same address bus.

Top module: `tx_sync_dist`

## Requirements
- R1: After reset all three registers read 0. The block is then in global mode with the pin as source, and no sync output pulses until the pin rises.
- R2: The registers can be written and read back at these addresses:
  - Configuration register at 0x10B. Bit 7 selects per-block mode (1 = per-block). Bits 4:0 are the per-target disables, in the order FIFO, divider, offset, gain/phase, mixer. Bit 5 is the mixer source select.
  - Source register at 0x10C. Bits 3:0 are the sources for FIFO, divider, offset and gain/phase. Bit 4 is the global source.
  - Trigger register at 0x10D. Bits 4:0 are the per-target triggers, in the same order as the disables. Bit 5 is the global trigger.
  - Undefined bits (configuration bit 6, source bits 7:5, trigger bits 7:6) and all other addresses read 0.
- R3: A pin sync is a rising edge of the pin after a two-flop synchronizer. The pulse appears on the outputs after the third clock edge that samples the pin high, and it lasts one cycle. A pin held high produces no further pulse.
- R4: In global mode with global source 0, a pin rise pulses all five outputs. No trigger bit has any effect.
- R5: In global mode with global source 1, a 0-to-1 write of trigger bit 5 pulses all five outputs in the cycle after the write edge. The pin and trigger bits 4:0 have no effect.
- R6: In global mode, the per-target source and disable bits have no effect on the outputs.
- R7: In per-block mode, a target that is enabled and has source 0 pulses on a pin rise. A target that is enabled and has source 1 pulses one cycle after a 0-to-1 write of its own trigger bit. The global trigger bit has no effect in this mode.
- R8: In per-block mode, a disabled target never pulses, whatever its source select says.
- R9: A trigger write that leaves a bit at 1 produces no pulse for that bit. A write that takes a bit from 1 to 0 also produces no pulse.
- R10: The mixer's source select is taken from configuration bit 5. The source register has no say over the mixer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sync_pin | input | 1 | External sync pin, asynchronous |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register address, used for both write and readback |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Readback of the register at reg_addr |
| sync_out | output | 5 | Sync pulses: bit 0 FIFO, 1 divider, 2 offset, 3 gain/phase, 4 mixer |

## Verification
The bench sweeps every combination of mode bit, five disables, five source selects and global source. For each combination it fires the pin and all six triggers, then predicts the five outputs arithmetically.

Each check targets a specific fault:
- A router that consults the per-target fields in global mode shows up as missing or extra pulses in the global half of the sweep.
- A trigger detector that works on level instead of edge pulses again when 1 is rewritten.
- A detector that fires on any change pulses on the 1-to-0 write.
- A wrong pipeline depth shows up because the bench also checks the cycle before each expected pulse and the cycle after it.
- Individual trigger writes expose crossed bit positions, including the mixer's source living in the configuration register.

// File: rtl/tx_sync_pkg.sv
package tx_sync_pkg;
   localparam int NUM_TGT        = 5;
   localparam int TGT_FIFO       = 0;
   localparam int TGT_DIV        = 1;
   localparam int TGT_QOFS       = 2;
   localparam int TGT_QGP        = 3;
   localparam int TGT_MIX        = 4;
   localparam int NUM_TRIG       = NUM_TGT + 1;
   localparam int GLOB_TRIG_BIT  = NUM_TGT;
   localparam int CFG_MIXSRC_BIT = 5;
   localparam int CFG_MODE_BIT   = 7;
   localparam int SRC_GLOB_BIT   = 4;
endpackage

// File: rtl/tx_sync_pin_edge.sv
module tx_sync_pin_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic pin_async,
   output logic pin_rise
);
   logic [STAGES-1:0] chain_q;
   logic              last_q;

   initial begin
      assert (STAGES >= 2) else $fatal(1, "synchronizer needs at least two stages");
   end

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (rst) chain_q[0] <= 1'b0;
               else     chain_q[0] <= pin_async;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (rst) chain_q[s] <= 1'b0;
               else     chain_q[s] <= chain_q[s-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) last_q <= 1'b0;
      else     last_q <= chain_q[STAGES-1];
   end

   assign pin_rise = chain_q[STAGES-1] & ~last_q;

   assert_pin_single_R3: assert property (@(posedge clk) disable iff (rst)
      pin_rise |=> !pin_rise);
endmodule

// File: rtl/tx_sync_regs.sv
module tx_sync_regs
   import tx_sync_pkg::*;
#(
   parameter int              ADDR_W    = 12,
   parameter int              DATA_W    = 8,
   parameter logic [ADDR_W-1:0] CFG_ADDR  = 12'h10B,
   parameter logic [ADDR_W-1:0] SRC_ADDR  = 12'h10C,
   parameter logic [ADDR_W-1:0] TRIG_ADDR = 12'h10D
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                we,
   input  logic [ADDR_W-1:0]   addr,
   input  logic [DATA_W-1:0]   wdata,
   output logic [DATA_W-1:0]   rdata,
   output logic                mode_per_blk,
   output logic [NUM_TGT-1:0]  tgt_dis,
   output logic [NUM_TGT-1:0]  tgt_src,
   output logic                glob_src,
   output logic [NUM_TRIG-1:0] sw_rise
);
   localparam logic [DATA_W-1:0] CFG_MASK  = DATA_W'((1 << CFG_MODE_BIT) | (1 << CFG_MIXSRC_BIT) | ((1 << NUM_TGT) - 1));
   localparam logic [DATA_W-1:0] SRC_MASK  = DATA_W'((1 << (SRC_GLOB_BIT + 1)) - 1);
   localparam logic [DATA_W-1:0] TRIG_MASK = DATA_W'((1 << NUM_TRIG) - 1);

   initial begin
      assert (DATA_W >= 8) else $fatal(1, "data width must hold the configuration byte");
      assert (CFG_ADDR != SRC_ADDR && SRC_ADDR != TRIG_ADDR && CFG_ADDR != TRIG_ADDR)
         else $fatal(1, "register addresses must differ");
   end

   logic [DATA_W-1:0] cfg_q, src_q, trig_q;
   logic wr_cfg, wr_src, wr_trig;

   assign wr_cfg  = we && (addr == CFG_ADDR);
   assign wr_src  = we && (addr == SRC_ADDR);
   assign wr_trig = we && (addr == TRIG_ADDR);

   always_ff @(posedge clk) begin
      if (rst) begin
         cfg_q   <= '0;
         src_q   <= '0;
         trig_q  <= '0;
         sw_rise <= '0;
      end else begin
         if (wr_cfg) cfg_q <= wdata & CFG_MASK;
         if (wr_src) src_q <= src_q ^ ((src_q ^ wdata) & SRC_MASK);
         if (wr_trig) begin
            trig_q  <= wdata & TRIG_MASK;
            sw_rise <= wdata[NUM_TRIG-1:0] & ~trig_q[NUM_TRIG-1:0];
         end else begin
            sw_rise <= '0;
         end
      end
   end

   always_comb begin
      if      (addr == CFG_ADDR)  rdata = cfg_q;
      else if (addr == SRC_ADDR)  rdata = src_q;
      else if (addr == TRIG_ADDR) rdata = trig_q;
      else                        rdata = '0;
   end

   assign mode_per_blk = cfg_q[CFG_MODE_BIT];
   assign tgt_dis      = cfg_q[NUM_TGT-1:0];
   assign glob_src     = src_q[SRC_GLOB_BIT];

   generate
      for (genvar t = 0; t < NUM_TGT; t++) begin : g_src
         if (t == TGT_MIX) begin : g_mix
            assign tgt_src[t] = cfg_q[CFG_MIXSRC_BIT];
         end else begin : g_reg
            assign tgt_src[t] = src_q[t];
         end
      end
   endgenerate

   assert_reset_clear_R1: assert property (@(posedge clk)
      rst |=> (cfg_q == '0 && src_q == '0 && trig_q == '0 && sw_rise == '0));

   generate
      for (genvar b = 0; b < NUM_TRIG; b++) begin : g_chk
         assert_no_retrigger_R9: assert property (@(posedge clk) disable iff (rst)
            (wr_trig && trig_q[b]) |=> !sw_rise[b]);
         assert_rise_single_R9: assert property (@(posedge clk) disable iff (rst)
            sw_rise[b] |=> !sw_rise[b]);
      end
   endgenerate
endmodule

// File: rtl/tx_sync_router.sv
module tx_sync_router
   import tx_sync_pkg::*;
(
   input  logic                clk,
   input  logic                rst,
   input  logic                pin_rise,
   input  logic [NUM_TRIG-1:0] sw_rise,
   input  logic                mode_per_blk,
   input  logic [NUM_TGT-1:0]  tgt_dis,
   input  logic [NUM_TGT-1:0]  tgt_src,
   input  logic                glob_src,
   output logic [NUM_TGT-1:0]  sync_q
);
   logic glob_pulse;

   assign glob_pulse = glob_src ? sw_rise[GLOB_TRIG_BIT] : pin_rise;

   generate
      for (genvar t = 0; t < NUM_TGT; t++) begin : g_tgt
         logic blk_pulse, nxt;
         assign blk_pulse = tgt_src[t] ? sw_rise[t] : pin_rise;
         assign nxt = mode_per_blk ? (!tgt_dis[t] && blk_pulse) : glob_pulse;

         always_ff @(posedge clk) begin
            if (rst) sync_q[t] <= 1'b0;
            else     sync_q[t] <= nxt;
         end

         assert_disabled_quiet_R8: assert property (@(posedge clk) disable iff (rst)
            (mode_per_blk && tgt_dis[t]) |=> !sync_q[t]);
         assert_blk_pin_R7: assert property (@(posedge clk) disable iff (rst)
            (mode_per_blk && !tgt_dis[t] && !tgt_src[t] && pin_rise) |=> sync_q[t]);
         assert_blk_sw_R7: assert property (@(posedge clk) disable iff (rst)
            (mode_per_blk && !tgt_dis[t] && tgt_src[t] && !sw_rise[t]) |=> !sync_q[t]);
      end
   endgenerate

   assert_glob_pin_R4: assert property (@(posedge clk) disable iff (rst)
      (!mode_per_blk && !glob_src && pin_rise) |=> (&sync_q));
   assert_glob_sw_R5: assert property (@(posedge clk) disable iff (rst)
      (!mode_per_blk && glob_src) |=> (sync_q == '0 || &sync_q));
endmodule

// File: rtl/tx_sync_dist.sv
module tx_sync_dist
   import tx_sync_pkg::*;
#(
   parameter int                ADDR_W      = 12,
   parameter int                DATA_W      = 8,
   parameter int                SYNC_STAGES = 2,
   parameter logic [ADDR_W-1:0] CFG_ADDR    = 12'h10B,
   parameter logic [ADDR_W-1:0] SRC_ADDR    = 12'h10C,
   parameter logic [ADDR_W-1:0] TRIG_ADDR   = 12'h10D
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               sync_pin,
   input  logic               reg_we,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic [DATA_W-1:0]  reg_wdata,
   output logic [DATA_W-1:0]  reg_rdata,
   output logic [NUM_TGT-1:0] sync_out
);
   logic                pin_rise;
   logic [NUM_TRIG-1:0] sw_rise;
   logic                mode_per_blk, glob_src;
   logic [NUM_TGT-1:0]  tgt_dis, tgt_src;

   tx_sync_pin_edge #(.STAGES(SYNC_STAGES)) i_pin (
      .clk(clk), .rst(rst), .pin_async(sync_pin), .pin_rise(pin_rise));

   tx_sync_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W),
      .CFG_ADDR(CFG_ADDR), .SRC_ADDR(SRC_ADDR), .TRIG_ADDR(TRIG_ADDR)
   ) i_regs (
      .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
      .rdata(reg_rdata), .mode_per_blk(mode_per_blk), .tgt_dis(tgt_dis),
      .tgt_src(tgt_src), .glob_src(glob_src), .sw_rise(sw_rise));

   tx_sync_router i_route (
      .clk(clk), .rst(rst), .pin_rise(pin_rise), .sw_rise(sw_rise),
      .mode_per_blk(mode_per_blk), .tgt_dis(tgt_dis), .tgt_src(tgt_src),
      .glob_src(glob_src), .sync_q(sync_out));

   assert_out_single_R3: assert property (@(posedge clk) disable iff (rst)
      (!reg_we && $stable(sync_pin) && (sync_out != '0)) |=> (sync_out == '0) || $past(reg_we));
endmodule

// File: tb/test_tx_sync_dist.sv
module test_tx_sync_dist;
   localparam logic [11:0] A_CFG  = 12'h10B;
   localparam logic [11:0] A_SRC  = 12'h10C;
   localparam logic [11:0] A_TRIG = 12'h10D;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       sync_pin = 1'b0;
   logic       reg_we = 1'b0;
   logic [11:0] reg_addr = '0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic [4:0] sync_out;

   int vectors = 0;
   int errors  = 0;

   always #5 clk = ~clk;

   tx_sync_dist i_tx_sync_dist (
      .clk(clk), .rst(rst), .sync_pin(sync_pin), .reg_we(reg_we),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .sync_out(sync_out));

   task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
      vectors++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %02h expected %02h at %0t", req, got, exp, $time);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd_check(input string req, input logic [11:0] a, input logic [7:0] exp);
      reg_addr = a;
      #1;
      check(req, reg_rdata, exp);
   endtask

   // trigger write then: no early pulse, pulse one cycle after write edge, then quiet
   task automatic trig_check(input string req, input logic [7:0] d, input logic [4:0] exp);
      wr(A_TRIG, d);
      check(req, {3'b0, sync_out}, 8'h00);
      @(negedge clk);
      check(req, {3'b0, sync_out}, {3'b0, exp});
      @(negedge clk);
      check(req, {3'b0, sync_out}, 8'h00);
   endtask

   task automatic pin_check(input string req, input logic [4:0] exp);
      @(negedge clk);
      sync_pin = 1'b1;
      @(negedge clk);
      @(negedge clk);
      check(req, {3'b0, sync_out}, 8'h00);
      @(negedge clk);
      check(req, {3'b0, sync_out}, {3'b0, exp});
      @(negedge clk);
      @(negedge clk);
      check(req, {3'b0, sync_out}, 8'h00);
      sync_pin = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   initial begin
      #1_900_000;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      // R1 reset state
      check("R1 out", {3'b0, sync_out}, 8'h00);
      rd_check("R1 cfg", A_CFG, 8'h00);
      rd_check("R1 src", A_SRC, 8'h00);
      rd_check("R1 trig", A_TRIG, 8'h00);
      rd_check("R2 unmapped", 12'h000, 8'h00);
      pin_check("R1 default pin route", 5'h1F);

      // exhaustive sweep over mode, disables, sources, global source
      for (int g = 0; g < 2; g++)
         for (int dis = 0; dis < 32; dis++)
            for (int s = 0; s < 32; s++)
               for (int gs = 0; gs < 2; gs++) begin
                  logic [7:0] cfgv, srcv;
                  logic [4:0] d5, s5, e_pin, e_sw;
                  d5 = dis[4:0]; s5 = s[4:0];
                  cfgv = {g[0], 1'b0, s5[4], d5};
                  srcv = {3'b0, gs[0], s5[3:0]};
                  wr(A_CFG, cfgv | 8'h40);
                  wr(A_SRC, srcv | 8'hE0);
                  rd_check("R2 cfg readback", A_CFG, cfgv);
                  rd_check("R2 src readback", A_SRC, srcv);
                  if (g == 1) begin
                     e_pin = ~d5 & ~s5;   // R7 R8 R10
                     e_sw  = ~d5 & s5;
                  end else begin
                     e_pin = gs[0] ? 5'h00 : 5'h1F;  // R4 R6
                     e_sw  = gs[0] ? 5'h1F : 5'h00;  // R5 R6
                  end
                  trig_check("R5 R7 trigger rise", 8'hFF, e_sw);
                  rd_check("R2 trig readback", A_TRIG, 8'h3F);
                  trig_check("R9 rewrite one", 8'h3F, 5'h00);
                  trig_check("R9 fall", 8'h00, 5'h00);
                  pin_check("R3 R4 R7 R8 pin", e_pin);
               end

      // per-block mode, all sources software: each bit hits only its target (R7, R10)
      wr(A_CFG, 8'hA0);
      wr(A_SRC, 8'h0F);
      for (int b = 0; b < 6; b++) begin
         trig_check("R7 single trigger", 8'(1 << b), (b < 5) ? 5'(1 << b) : 5'h00);
         trig_check("R9 clear", 8'h00, 5'h00);
      end
      // mixer source from config only: source register bit 4 must not route it (R10)
      wr(A_CFG, 8'h80);
      wr(A_SRC, 8'h10);
      trig_check("R10 mixer pin source", 8'h10, 5'h00);
      trig_check("R9 clear", 8'h00, 5'h00);
      pin_check("R10 mixer pin source", 5'h1F);
      // global mode, software source: per-block trigger bits ignored (R5)
      wr(A_CFG, 8'h00);
      wr(A_SRC, 8'h10);
      trig_check("R5 per-block bits ignored", 8'h1F, 5'h00);
      trig_check("R5 global rise", 8'h3F, 5'h1F);
      trig_check("R9 clear", 8'h00, 5'h00);

      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule